// File: doc/BRIEF.md
# SD Command Line Transceiver

This block drives the single-bit command line of an SD card bus and collects the card's answer for a controlling sequencer. The sequencer gives a one-cycle request that carries a 6-bit command number, a 32-bit argument, the length of the response it expects and a flag that enables the response CRC check. The block builds the 48-bit command token, appends a CRC7 that it computes itself, and sends the token one bit per bit-rate enable tick. It then releases the line and waits for the card's response.

A response is either absent, 48 bits long or 136 bits long. The block waits for the start bit, shifts in the requested number of bits, and then checks the end bit and, when enabled, the CRC7. It then reports the outcome with a one-cycle pulse on exactly one of two outputs. The received bits stay right-aligned on a 136-bit output until the next command is accepted. Bit timing comes only from the external enable, so the same logic runs at the slow identification rate and at full bus speed. A fixed number of idle bit periods separates each outcome from the next accepted command.

Top module: `sd_cmd_xcvr`

## Requirements
- R1: While reset is asserted and directly after it, `cmdOut` is 1 and `replyReady` and `replyError` are 0.
- R2: An accepted request is sent at the first `bitTick` after acceptance as a 48-bit token, most significant bit first. The token is a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a 7-bit CRC and a 1 end bit. Each bit is held for one tick period, and `cmdOut` changes only at a clock edge where `bitTick` is high.
- R3: The token CRC is the CRC7 with polynomial x^7+x^3+1 and an all-zero seed, taken over the first 40 token bits and placed in token bits 7:1.
- R4: When `respLen` is 0, no response is awaited and `replyReady` pulses right after the token's end bit.
- R5: When `respLen` is any value other than 0 or 136, a 48-bit response is expected. Its first bit is the first 0 sampled on a tick after the token, and it appears on `replyData[47:0]` with bits 135:48 zero. Bits 45:40 hold the echoed index and bits 39:8 hold the payload.
- R6: When `respLen` is 136, a 136-bit response is shifted in and appears on `replyData[135:0]`. Its CRC7 covers bits 127:8 and is compared with bits 7:1.
- R7: With `respCrcChk` at 1, a CRC mismatch ends the command with `replyError`. With it at 0, the mismatch is ignored and the command ends with `replyReady`.
- R8: A received end bit (`replyData[0]`) of 0 ends the command with `replyError`.
- R9: If 64 ticks after the token all sample 1, the command ends with `replyError`. A start bit sampled on the 64th tick is still accepted.
- R10: Each accepted command produces exactly one one-cycle pulse, either on `replyReady` or on `replyError`, never both.
- R11: A request made while a command is in progress is ignored.
- R12: After each outcome, a request is ignored until 8 tick periods have passed.
- R13: `cmdOut` is 1 at all times except during the 48 token bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | Bit-rate enable, one clock wide |
| cmdValid | input | 1 | One-cycle command request |
| cmdIndex | input | 6 | Command number |
| cmdArg | input | 32 | Command argument |
| respLen | input | 8 | Expected response length in bits: 0, 48 or 136 |
| respCrcChk | input | 1 | 1: response CRC7 is checked |
| cmdOut | output | 1 | Value driven toward the command line |
| cmdIn | input | 1 | Sampled command line |
| replyReady | output | 1 | Pulse: response received and valid |
| replyData | output | 136 | Received response, right-aligned |
| replyError | output | 1 | Pulse: timeout, CRC or end-bit failure |

## Verification
The assertions check on every cycle that the two outcome pulses are exclusive and one cycle long, that the line changes only at tick edges, and that the line is released whenever an outcome is reported. The token contents, the CRC values, the alignment of short and long responses, the per-command CRC flag, the end-bit and timeout failures, and the ignoring of requests while busy or during the idle gap can only be shown by the bench's scenarios. The bench plays the card and compares everything against a CRC model of its own.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;

  localparam int TOKEN_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_W      = 7;
  localparam int IDX_W      = $clog2(LONG_BITS);
  // last bit index covered by the CRC in a 48-bit frame
  localparam int SHORT_CRC_HI = TOKEN_BITS - CRC_W - 2;
  // window covered by the CRC in a 136-bit frame
  localparam int LONG_CRC_LO  = LONG_BITS - 128;
  localparam int LONG_CRC_HI  = LONG_BITS - CRC_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_TX, ST_WAIT, ST_RX, ST_CHECK, ST_GAP
  } lnkState_t;

  typedef enum logic [1:0] {RSP_NONE, RSP_SHORT, RSP_LONG} rspKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic txStep;
    logic txCrcLoad;
    logic rxStart;
    logic rxStep;
    logic crcEn;
    logic crcFromRx;
    logic driveTx;
  } dpCtl_t;

  function automatic logic [CRC_W-1:0] crc7Step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb   = b ^ c[CRC_W-1];
    n    = {c[CRC_W-2:0], fb};
    n[3] = c[2] ^ fb;
    return n;
  endfunction

endpackage

// File: rtl/sd_cmd_dp.sv
`timescale 1ns/1ps
module sd_cmd_dp
  import sd_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic [5:0]            cmdIndex,
  input  logic [31:0]           cmdArg,
  input  logic                  cmdIn,
  output logic                  cmdOut,
  output logic [LONG_BITS-1:0]  replyData,
  output logic                  crcMatch,
  output logic                  endBitOk
);

  logic [TOKEN_BITS-1:0] txShift;
  logic [LONG_BITS-1:0]  rxShift;
  logic [CRC_W-1:0]      crcReg;
  logic [CRC_W-1:0]      crcNext;
  logic                  crcBit;

  assign crcBit  = ctl.crcFromRx ? cmdIn : txShift[TOKEN_BITS-1];
  assign crcNext = crc7Step(crcReg, crcBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (ctl.load) begin
      txShift <= {2'b01, cmdIndex, cmdArg, 8'h00};
    end else if (ctl.txCrcLoad) begin
      txShift <= {crcNext, 1'b1, {(TOKEN_BITS-CRC_W-1){1'b0}}};
    end else if (ctl.txStep) begin
      txShift <= {txShift[TOKEN_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (ctl.load) begin
      rxShift <= '0;
    end else if (ctl.rxStart || ctl.rxStep) begin
      rxShift <= {rxShift[LONG_BITS-2:0], cmdIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (ctl.load || ctl.rxStart) begin
      crcReg <= '0;
    end else if (ctl.crcEn) begin
      crcReg <= crcNext;
    end
  end

  assign cmdOut    = ctl.driveTx ? txShift[TOKEN_BITS-1] : 1'b1;
  assign replyData = rxShift;
  assign crcMatch  = (crcReg == rxShift[CRC_W:1]);
  assign endBitOk  = rxShift[0];

endmodule

// File: rtl/sd_cmd_ctrl.sv
`timescale 1ns/1ps
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int WAIT_LIMIT = 64,
  parameter int IDLE_GAP   = 8
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       cmdValid,
  input  logic [7:0] respLen,
  input  logic       respCrcChk,
  input  logic       cmdIn,
  input  logic       crcMatch,
  input  logic       endBitOk,
  output dpCtl_t     ctl,
  output logic       replyReady,
  output logic       replyError
);

  localparam int WAIT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
  localparam logic [IDX_W-1:0] TX_LAST    = IDX_W'(TOKEN_BITS - 1);
  localparam logic [IDX_W-1:0] TX_CRC_HI  = IDX_W'(SHORT_CRC_HI);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_LO    = IDX_W'(LONG_CRC_LO);
  localparam logic [IDX_W-1:0] LONG_HI    = IDX_W'(LONG_CRC_HI);
  localparam logic [IDX_W-1:0] GAP_LAST   = IDX_W'(IDLE_GAP - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT - 1);

  lnkState_t         state;
  rspKind_t          rspKind;
  logic              chkQ;
  logic [IDX_W-1:0]  bitIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic [IDX_W-1:0]  rxLast;
  logic              crcWindow;
  rspKind_t          reqKind;

  assign rxLast    = (rspKind == RSP_LONG) ? LONG_LAST : TX_LAST;
  assign crcWindow = (rspKind == RSP_LONG) ? (bitIdx >= LONG_LO && bitIdx <= LONG_HI)
                                           : (bitIdx <= TX_CRC_HI);

  always_comb begin
    if (respLen == 8'd0)                 reqKind = RSP_NONE;
    else if (respLen == 8'(LONG_BITS))   reqKind = RSP_LONG;
    else                                 reqKind = RSP_SHORT;
  end

  always_comb begin
    ctl           = '0;
    ctl.load      = (state == ST_IDLE) && cmdValid;
    ctl.driveTx   = (state == ST_TX);
    ctl.txStep    = (state == ST_TX) && bitTick;
    ctl.txCrcLoad = (state == ST_TX) && bitTick && (bitIdx == TX_CRC_HI);
    ctl.crcFromRx = (state == ST_RX);
    ctl.rxStart   = (state == ST_WAIT) && bitTick && !cmdIn;
    ctl.rxStep    = (state == ST_RX) && bitTick;
    ctl.crcEn     = ((state == ST_TX) && bitTick && (bitIdx <= TX_CRC_HI)) ||
                    ((state == ST_RX) && bitTick && crcWindow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rspKind    <= RSP_NONE;
      chkQ       <= 1'b0;
      bitIdx     <= '0;
      waitCnt    <= '0;
      replyReady <= 1'b0;
      replyError <= 1'b0;
    end else begin
      replyReady <= 1'b0;
      replyError <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmdValid) begin
          rspKind <= reqKind;
          chkQ    <= respCrcChk;
          state   <= ST_ARM;
        end
        ST_ARM: if (bitTick) begin
          bitIdx <= '0;
          state  <= ST_TX;
        end
        ST_TX: if (bitTick) begin
          if (bitIdx == TX_LAST) begin
            bitIdx  <= '0;
            waitCnt <= '0;
            if (rspKind == RSP_NONE) begin
              replyReady <= 1'b1;
              state      <= ST_GAP;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_WAIT: if (bitTick) begin
          if (!cmdIn) begin
            bitIdx <= IDX_W'(1);
            state  <= ST_RX;
          end else if (waitCnt == WAIT_LAST) begin
            replyError <= 1'b1;
            bitIdx     <= '0;
            state      <= ST_GAP;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RX: if (bitTick) begin
          if (bitIdx == rxLast) state <= ST_CHECK;
          else                  bitIdx <= bitIdx + 1'b1;
        end
        ST_CHECK: begin
          if (!endBitOk || (chkQ && !crcMatch)) replyError <= 1'b1;
          else                                  replyReady <= 1'b1;
          bitIdx <= '0;
          state  <= ST_GAP;
        end
        ST_GAP: if (bitTick) begin
          if (bitIdx == GAP_LAST) state <= ST_IDLE;
          else                    bitIdx <= bitIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_xcvr.sv
`timescale 1ns/1ps
module sd_cmd_xcvr
  import sd_cmd_pkg::*;
#(
  parameter int WAIT_LIMIT = 64,
  parameter int IDLE_GAP   = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 cmdValid,
  input  logic [5:0]           cmdIndex,
  input  logic [31:0]          cmdArg,
  input  logic [7:0]           respLen,
  input  logic                 respCrcChk,
  output logic                 cmdOut,
  input  logic                 cmdIn,
  output logic                 replyReady,
  output logic [LONG_BITS-1:0] replyData,
  output logic                 replyError
);

  dpCtl_t ctl;
  logic   crcMatch;
  logic   endBitOk;

  sd_cmd_ctrl #(.WAIT_LIMIT(WAIT_LIMIT), .IDLE_GAP(IDLE_GAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cmdValid(cmdValid),
    .respLen(respLen), .respCrcChk(respCrcChk), .cmdIn(cmdIn),
    .crcMatch(crcMatch), .endBitOk(endBitOk), .ctl(ctl),
    .replyReady(replyReady), .replyError(replyError)
  );

  sd_cmd_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .cmdIn(cmdIn), .cmdOut(cmdOut), .replyData(replyData),
    .crcMatch(crcMatch), .endBitOk(endBitOk)
  );

endmodule

// File: rtl/sd_cmd_xcvr_chk.sv
`timescale 1ns/1ps
module sd_cmd_xcvr_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic cmdOut,
  input logic replyReady,
  input logic replyError
);

  // R10
  ready_error_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(replyReady && replyError));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    replyReady |=> !replyReady);

  // R10
  error_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    replyError |=> !replyError);

  // R2
  line_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdOut) |-> $past(bitTick));

  // R13
  released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replyReady || replyError) |-> cmdOut);

endmodule

bind sd_cmd_xcvr sd_cmd_xcvr_chk chk_i (.*);

// File: tb/sd_cmd_xcvr_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_xcvr_tb_top;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [7:0]  len;
    logic        chk;
    logic [7:0]  lat;   // 255: card stays silent
    logic [1:0]  bad;   // 1: corrupt CRC, 2: end bit 0
    logic        expErr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 8'd0,   1'b0, 8'd0,   2'd0, 1'b0},
    '{6'd8,  32'h0000_01AA, 8'd48,  1'b1, 8'd2,   2'd0, 1'b0},
    '{6'd55, 32'h1234_0000, 8'd48,  1'b1, 8'd0,   2'd0, 1'b0},
    '{6'd41, 32'h40FF_8000, 8'd48,  1'b0, 8'd3,   2'd1, 1'b0},
    '{6'd17, 32'hDEAD_BEEF, 8'd48,  1'b1, 8'd1,   2'd1, 1'b1},
    '{6'd2,  32'h0000_0000, 8'd136, 1'b1, 8'd5,   2'd0, 1'b0},
    '{6'd9,  32'hCAFE_0000, 8'd136, 1'b1, 8'd4,   2'd1, 1'b1},
    '{6'd3,  32'h0000_0000, 8'd48,  1'b1, 8'd2,   2'd2, 1'b1},
    '{6'd7,  32'hABCD_0000, 8'd48,  1'b1, 8'd63,  2'd0, 1'b0},
    '{6'd13, 32'h5555_AAAA, 8'd48,  1'b1, 8'd255, 2'd0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         bitTick = 1'b0;
  logic         cmdValid;
  logic [5:0]   cmdIndex;
  logic [31:0]  cmdArg;
  logic [7:0]   respLen;
  logic         respCrcChk;
  logic         cmdOut;
  logic         cmdIn;
  logic         replyReady;
  logic [135:0] replyData;
  logic         replyError;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  sd_cmd_xcvr dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cmdValid(cmdValid),
    .cmdIndex(cmdIndex), .cmdArg(cmdArg), .respLen(respLen),
    .respCrcChk(respCrcChk), .cmdOut(cmdOut), .cmdIn(cmdIn),
    .replyReady(replyReady), .replyData(replyData), .replyError(replyError)
  );

  always #4 clk = ~clk;

  // enable every fourth clock, changed just after the rising edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #1;
      phase   = (phase + 1) % 4;
      bitTick = (phase == 3);
    end
  end

  function automatic logic [6:0] crcOf(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], fb};
      c[3] = c[3] ^ fb;
    end
    return c;
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tickWait();
    do @(negedge clk); while (!bitTick);
  endtask

  task automatic sendCmd(input logic [5:0] i, input logic [31:0] a,
                         input logic [7:0] l, input logic c);
    cmdIndex = i; cmdArg = a; respLen = l; respCrcChk = c; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic captureToken(output logic [47:0] tok, output bit ok);
    int guard = 0;
    tok = '1;
    tickWait();
    while (cmdOut && guard < 20) begin
      tickWait();
      guard++;
    end
    ok = !cmdOut;
    tok[47] = cmdOut;
    for (int i = 46; i >= 0; i--) begin
      tickWait();
      tok[i] = cmdOut;
    end
  endtask

  // 1: ready, 2: error, 3: both, 0: none; also checks the pulse width
  task automatic waitResult(output int code, input string req);
    int n = 0;
    code = 0;
    while (n < 3000 && !replyReady && !replyError) begin
      @(negedge clk);
      n++;
    end
    code = (replyReady ? 1 : 0) + (replyError ? 2 : 0);
    @(negedge clk);
    check(!replyReady && !replyError, {req, " R10"}, "pulse longer than one cycle",
          {134'd0, replyError, replyReady}, 136'd0);
  endtask

  task automatic expectSilent(input int n, input string req);
    int lows = 0;
    repeat (n) begin
      tickWait();
      if (!cmdOut) lows++;
    end
    check(lows == 0, req, "unexpected token bits", 136'(lows), 136'd0);
  endtask

  function automatic logic [47:0] tokenOf(input logic [5:0] i, input logic [31:0] a);
    logic [135:0] t = '0;
    t[47:0] = {2'b01, i, a, 8'h01};
    t[7:1]  = crcOf(t, 47, 8);
    return t[47:0];
  endfunction

  task automatic runVector(input vec_t v);
    logic [47:0]  tok;
    logic [135:0] rsp;
    bit           ok;
    int           code;
    int           lows;
    int           rlen;
    string        tag;
    rlen = (v.len == 8'd136) ? 136 : 48;
    if (v.len == 8'd0)          tag = "R4";
    else if (v.lat == 8'd255)   tag = "R9";
    else if (v.bad == 2'd2)     tag = "R8";
    else if (v.bad == 2'd1)     tag = "R7";
    else if (v.lat == 8'd63)    tag = "R9";
    else if (rlen == 136)       tag = "R6";
    else                        tag = "R5";

    rsp = '0;
    if (rlen == 136) begin
      rsp = {8'h3F, v.arg ^ 32'h1357_9BDF, ~v.arg, v.arg, 24'hC35A96, 8'h01};
      rsp[7:1] = crcOf(rsp, 127, 8);
    end else begin
      rsp[47:0] = {2'b00, v.idx, v.arg ^ 32'hA5A5_0F0F, 8'h01};
      rsp[7:1]  = crcOf(rsp, 47, 8);
    end
    if (v.bad == 2'd1) rsp[1] = ~rsp[1];
    if (v.bad == 2'd2) rsp[0] = 1'b0;

    sendCmd(v.idx, v.arg, v.len, v.chk);
    captureToken(tok, ok);
    check(ok && tok == tokenOf(v.idx, v.arg), "R2 R3", "token",
          136'(tok), 136'(tokenOf(v.idx, v.arg)));

    if (v.len != 8'd0 && v.lat != 8'd255) begin
      lows = 0;
      repeat (int'(v.lat)) begin
        tickWait();
        if (!cmdOut) lows++;
      end
      check(lows == 0, "R13", "line low while awaiting response", 136'(lows), 136'd0);
      for (int i = rlen - 1; i >= 0; i--) begin
        tickWait();
        cmdIn = rsp[i];
      end
      @(negedge clk);
      cmdIn = 1'b1;
    end

    waitResult(code, tag);
    check(code == (v.expErr ? 2 : 1), {tag, " R10"}, "outcome",
          136'(code), 136'(v.expErr ? 2 : 1));
    if (!v.expErr && v.len != 8'd0)
      check(replyData == rsp, tag, "response data", replyData, rsp);
    repeat (10) tickWait();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] tok;
    bit ok;
    int code;
    rstN = 1'b0; cmdValid = 1'b0; cmdIndex = '0; cmdArg = '0;
    respLen = '0; respCrcChk = 1'b0; cmdIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(cmdOut && !replyReady && !replyError, "R1", "reset outputs",
          {133'd0, cmdOut, replyError, replyReady}, 136'd4);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(cmdOut && !replyReady && !replyError, "R1", "outputs after reset",
          {133'd0, cmdOut, replyError, replyReady}, 136'd4);

    foreach (VECS[k]) runVector(VECS[k]);

    // R11: a second request during transmission is dropped
    sendCmd(6'd5, 32'h0F0F_0F0F, 8'd0, 1'b0);
    fork
      captureToken(tok, ok);
      begin
        repeat (12) tickWait();
        sendCmd(6'd6, 32'hFFFF_FFFF, 8'd48, 1'b1);
      end
    join
    check(ok && tok == tokenOf(6'd5, 32'h0F0F_0F0F), "R11", "token while busy",
          136'(tok), 136'(tokenOf(6'd5, 32'h0F0F_0F0F)));
    waitResult(code, "R11");
    check(code == 1, "R11", "outcome of first request", 136'(code), 136'd1);
    expectSilent(40, "R11");

    // R12: request on the 8th tick of the idle gap is ignored, later one accepted
    sendCmd(6'd20, 32'h0000_0020, 8'd0, 1'b0);
    captureToken(tok, ok);
    waitResult(code, "R12");
    check(code == 1, "R12", "outcome before gap", 136'(code), 136'd1);
    repeat (8) tickWait();
    sendCmd(6'd21, 32'h0000_0021, 8'd0, 1'b0);
    expectSilent(40, "R12");
    sendCmd(6'd22, 32'h0000_0022, 8'd0, 1'b0);
    captureToken(tok, ok);
    check(ok && tok == tokenOf(6'd22, 32'h0000_0022), "R12", "token after gap",
          136'(tok), 136'(tokenOf(6'd22, 32'h0000_0022)));
    waitResult(code, "R12");
    check(code == 1, "R12", "outcome after gap", 136'(code), 136'd1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule